// File: doc/BRIEF.md
# Configurable Logic Cell with Pin Control

This block is one programmable logic cell. It receives a single sum-of-products term and turns it into a cell output in one of three ways: straight through as combinational logic, stored in an edge-triggered flip-flop that can work as a D or a T element, or held in a level-sensitive latch. After the storage stage an optional inverter sets the output polarity. The result always goes back to the logic array as feedback. In the pin-facing variant it also drives a three-state pin.

Each cell takes two shared clock/gate lines and picks one of them. Every cell in a group also sees the same asynchronous clear and set terms and the same set of output-enable terms. The pin enable can be forced on, forced off, or taken from one of the shared enable terms. When the parameter `BURIED` is set, the cell has no pin drive. In that variant the cell can store the value on the pin input in place of the sum term, which makes it an input register or input latch. All configuration inputs are static settings and are not meant to change during operation.

Top module: `mc_cell`

## Requirements
- R1: `cfg_mode` selects the behaviour: 0 = combinational, 1 = registered, 2 = latched, 3 = combinational. In combinational mode `fb_out` equals the data term XOR `cfg_invert`, with no clock involved.
- R2: In registered mode with `cfg_tff`=0, the data term is captured on the rising edge of the selected clock line. Between edges the output holds.
- R3: In registered mode with `cfg_tff`=1, a data term of 1 inverts the stored bit at each rising edge of the selected line. A data term of 0 leaves the bit unchanged.
- R4: `cfg_clk_sel`=0 picks `clk_a` and `cfg_clk_sel`=1 picks `clk_b`. Edges on the line that is not picked have no effect on the stored bit.
- R5: In latched mode the stored bit follows the data term while the selected line is LOW. It holds its value while that line is HIGH.
- R6: `ar_in`=1 forces the stored bit to 0 and `ap_in`=1 forces it to 1, both with no clock. When both are high, the bit is 0.
- R7: Polarity inversion (`cfg_invert`=1) is applied after the storage element. It acts the same way on `fb_out` and on `pin_out`, and in the pin variant the two are always equal.
- R8: `cfg_oe_mode` sets `pin_oe`: 0 = always off, 1 = always on, 2 = the enable term `oe_term[cfg_oe_pick]`, 3 = off.
- R9: With `BURIED`=1, `pin_oe` and `pin_out` stay 0 at all times. If `cfg_pin_capture`=1, the data term is `pin_in` in place of `sum_in`. With `BURIED`=0, `cfg_pin_capture` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First shared clock/gate line |
| clk_b | input | 1 | Second shared clock/gate line |
| sum_in | input | 1 | Sum term from the product-term array |
| ar_in | input | 1 | Shared asynchronous clear term, active high |
| ap_in | input | 1 | Shared asynchronous set term, active high |
| oe_term | input | N_OE | Shared output-enable terms |
| pin_in | input | 1 | Value read from the pin |
| cfg_mode | input | 2 | Cell mode (R1) |
| cfg_tff | input | 1 | 1 = T flip-flop, 0 = D flip-flop |
| cfg_clk_sel | input | 1 | Clock/gate line select |
| cfg_invert | input | 1 | Output polarity inversion |
| cfg_oe_mode | input | 2 | Pin enable mode (R8) |
| cfg_oe_pick | input | $clog2(N_OE) | Index of the shared enable term |
| cfg_pin_capture | input | 1 | Buried variant: store pin input |
| fb_out | output | 1 | Feedback to the logic array |
| pin_out | output | 1 | Pin data drive |
| pin_oe | output | 1 | Pin drive enable |

## Verification
The following hold on every rising edge of `clk_a` and are checked there: combinational pass-through, D capture and T toggling when `clk_a` is the selected line, hold of the latch while its gate stays HIGH, forced-off enable modes, and the quiet pin of the buried variant. The bench's scenarios are needed for the rest, because it happens between edges or on the second clock line. That covers clear/set priority, capture on `clk_b`, edges on the line that is not selected, transparent latch tracking, polarity on both outputs, enable-term selection, and pin capture in the buried cell.

// File: rtl/mc_pkg.sv
package mc_pkg;

    typedef enum logic [1:0] {
        MC_COMB  = 2'd0,
        MC_REG   = 2'd1,
        MC_LATCH = 2'd2,
        MC_COMB2 = 2'd3
    } mc_mode_e;

    typedef enum logic [1:0] {
        OE_NEVER  = 2'd0,
        OE_ALWAYS = 2'd1,
        OE_TERM   = 2'd2,
        OE_SPARE  = 2'd3
    } mc_oe_e;

endpackage

// File: rtl/mc_src_sel.sv
module mc_src_sel #(
    parameter bit BURIED = 1'b0
) (
    input  logic sum_in,
    input  logic pin_in,
    input  logic cfg_pin_capture,
    output logic data_o
);

    generate
        if (BURIED) begin : g_buried
            // Input-register use: the pin value replaces the logic sum.
            always_comb data_o = cfg_pin_capture ? pin_in : sum_in;
        end else begin : g_pin
            // The pin variant always uses the sum; the other inputs are
            // folded in with a constant so that every input is read.
            logic unused_in;
            always_comb unused_in = pin_in & cfg_pin_capture & 1'b0;
            always_comb data_o    = sum_in | unused_in;
        end
    endgenerate

endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic     clk_a,
    input  logic     clk_b,
    input  logic     clk_sel,
    input  logic     ar,
    input  logic     ap,
    input  logic     d,
    input  logic     tff,
    input  mc_mode_e mode,
    output logic     q
);

    logic line_sel;
    logic q_ff;
    logic q_lat;

    always_comb line_sel = clk_sel ? clk_b : clk_a;

    // Edge-triggered element; clear beats set.
    always_ff @(posedge line_sel or posedge ar or posedge ap) begin
        if (ar)
            q_ff <= 1'b0;
        else if (ap)
            q_ff <= 1'b1;
        else if (tff)
            q_ff <= q_ff ^ d;
        else
            q_ff <= d;
    end

    // Level-sensitive element: open while the gate line is LOW.
    always_latch begin
        if (ar)
            q_lat = 1'b0;
        else if (ap)
            q_lat = 1'b1;
        else if (!line_sel)
            q_lat = d;
    end

    always_comb begin
        unique case (mode)
            MC_REG:   q = q_ff;
            MC_LATCH: q = q_lat;
            MC_COMB:  q = d;
            MC_COMB2: q = d;
        endcase
    end

endmodule

// File: rtl/mc_oe_ctl.sv
module mc_oe_ctl
    import mc_pkg::*;
#(
    parameter bit BURIED   = 1'b0,
    parameter int N_OE     = 2,
    localparam int SEL_W   = (N_OE > 1) ? $clog2(N_OE) : 1
) (
    input  logic [N_OE-1:0]  oe_term,
    input  mc_oe_e           oe_mode,
    input  logic [SEL_W-1:0] oe_pick,
    output logic             oe_o
);

    logic term_val;
    logic en_raw;

    always_comb term_val = (int'(oe_pick) < N_OE) ? oe_term[oe_pick] : 1'b0;

    always_comb begin
        unique case (oe_mode)
            OE_NEVER:  en_raw = 1'b0;
            OE_ALWAYS: en_raw = 1'b1;
            OE_TERM:   en_raw = term_val;
            OE_SPARE:  en_raw = 1'b0;
        endcase
    end

    generate
        if (BURIED) begin : g_no_pin
            always_comb oe_o = en_raw & 1'b0;
        end else begin : g_pin
            always_comb oe_o = en_raw;
        end
    endgenerate

endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
#(
    parameter bit BURIED  = 1'b0,
    parameter int N_OE    = 2,
    localparam int SEL_W  = (N_OE > 1) ? $clog2(N_OE) : 1
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             sum_in,
    input  logic             ar_in,
    input  logic             ap_in,
    input  logic [N_OE-1:0]  oe_term,
    input  logic             pin_in,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_tff,
    input  logic             cfg_clk_sel,
    input  logic             cfg_invert,
    input  logic [1:0]       cfg_oe_mode,
    input  logic [SEL_W-1:0] cfg_oe_pick,
    input  logic             cfg_pin_capture,
    output logic             fb_out,
    output logic             pin_out,
    output logic             pin_oe
);

    logic data_w;
    logic store_q;
    logic cell_val;

    mc_src_sel #(.BURIED(BURIED)) u_src (
        .sum_in          (sum_in),
        .pin_in          (pin_in),
        .cfg_pin_capture (cfg_pin_capture),
        .data_o          (data_w)
    );

    mc_store u_store (
        .clk_a   (clk_a),
        .clk_b   (clk_b),
        .clk_sel (cfg_clk_sel),
        .ar      (ar_in),
        .ap      (ap_in),
        .d       (data_w),
        .tff     (cfg_tff),
        .mode    (mc_mode_e'(cfg_mode)),
        .q       (store_q)
    );

    mc_oe_ctl #(.BURIED(BURIED), .N_OE(N_OE)) u_oe (
        .oe_term (oe_term),
        .oe_mode (mc_oe_e'(cfg_oe_mode)),
        .oe_pick (cfg_oe_pick),
        .oe_o    (pin_oe)
    );

    // Polarity after storage feeds both paths.
    always_comb cell_val = store_q ^ cfg_invert;
    always_comb fb_out   = cell_val;

    generate
        if (BURIED) begin : g_no_drive
            always_comb pin_out = 1'b0;
        end else begin : g_drive
            always_comb pin_out = cell_val;
        end
    endgenerate

endmodule

// File: rtl/mc_cell_chk.sv
module mc_cell_chk #(
    parameter bit BURIED = 1'b0,
    parameter int N_OE   = 2,
    localparam int SEL_W = (N_OE > 1) ? $clog2(N_OE) : 1
) (
    input logic             clk_a,
    input logic             clk_b,
    input logic             sum_in,
    input logic             ar_in,
    input logic             ap_in,
    input logic [N_OE-1:0]  oe_term,
    input logic             pin_in,
    input logic [1:0]       cfg_mode,
    input logic             cfg_tff,
    input logic             cfg_clk_sel,
    input logic             cfg_invert,
    input logic [1:0]       cfg_oe_mode,
    input logic [SEL_W-1:0] cfg_oe_pick,
    input logic             cfg_pin_capture,
    input logic             fb_out,
    input logic             pin_out,
    input logic             pin_oe
);

    logic [5:0] cfg_now;
    logic [5:0] cfg_prev;
    logic       cfg_moved;
    logic       gate_prev;
    logic       src_is_sum;
    logic       oe_unused;

    always_comb cfg_now    = {cfg_mode, cfg_tff, cfg_clk_sel, cfg_invert, cfg_pin_capture};
    always_comb cfg_moved  = (cfg_now != cfg_prev);
    always_comb src_is_sum = (BURIED == 1'b0) || !cfg_pin_capture;
    always_comb oe_unused  = ^{oe_term, cfg_oe_pick, pin_in};

    always_ff @(posedge clk_a) begin
        cfg_prev  <= cfg_now;
        gate_prev <= clk_b;
    end

    AST_COMB_PASS: assert property (@(posedge clk_a) disable iff (ar_in || ap_in)
        ((cfg_mode == 2'd0 || cfg_mode == 2'd3) && src_is_sum) |-> (fb_out == (sum_in ^ cfg_invert))); // R1

    AST_DFF_CAPTURE: assert property (@(posedge clk_a) disable iff (ar_in || ap_in)
        (cfg_mode == 2'd1 && !cfg_tff && !cfg_clk_sel && src_is_sum)
        |=> (cfg_moved || fb_out == ($past(sum_in) ^ cfg_invert))); // R2

    AST_TFF_TOGGLE: assert property (@(posedge clk_a) disable iff (ar_in || ap_in)
        (cfg_mode == 2'd1 && cfg_tff && !cfg_clk_sel && src_is_sum && sum_in)
        |=> (cfg_moved || fb_out != $past(fb_out))); // R3

    AST_LATCH_HOLD: assert property (@(posedge clk_a) disable iff (ar_in || ap_in)
        (cfg_mode == 2'd2 && cfg_clk_sel && clk_b && gate_prev && !cfg_moved)
        |-> $stable(fb_out)); // R5

    AST_OE_FORCED_OFF: assert property (@(posedge clk_a) disable iff (ar_in && oe_unused)
        (cfg_oe_mode == 2'd0 || cfg_oe_mode == 2'd3) |-> !pin_oe); // R8

    generate
        if (BURIED) begin : g_bur
            AST_BURIED_QUIET: assert property (@(posedge clk_a) disable iff (ar_in && ap_in)
                (!pin_oe && !pin_out)); // R9
        end else begin : g_pin
            AST_PIN_MATCH: assert property (@(posedge clk_a) disable iff (ar_in && ap_in)
                (pin_out == fb_out)); // R7
        end
    endgenerate

endmodule

bind mc_cell mc_cell_chk #(.BURIED(BURIED), .N_OE(N_OE)) u_chk (
    .clk_a           (clk_a),
    .clk_b           (clk_b),
    .sum_in          (sum_in),
    .ar_in           (ar_in),
    .ap_in           (ap_in),
    .oe_term         (oe_term),
    .pin_in          (pin_in),
    .cfg_mode        (cfg_mode),
    .cfg_tff         (cfg_tff),
    .cfg_clk_sel     (cfg_clk_sel),
    .cfg_invert      (cfg_invert),
    .cfg_oe_mode     (cfg_oe_mode),
    .cfg_oe_pick     (cfg_oe_pick),
    .cfg_pin_capture (cfg_pin_capture),
    .fb_out          (fb_out),
    .pin_out         (pin_out),
    .pin_oe          (pin_oe)
);

// File: tb/mc_cell_tb.sv
module mc_cell_tb;

    logic       clk = 1'b0;
    logic       clk_b = 1'b0;
    logic       sum_in = 1'b0;
    logic       ar_in = 1'b1;
    logic       ap_in = 1'b0;
    logic [1:0] oe_term = 2'b00;
    logic       pin_in = 1'b0;
    logic [1:0] cfg_mode = 2'd1;
    logic       cfg_tff = 1'b0;
    logic       cfg_clk_sel = 1'b1;
    logic       cfg_invert = 1'b0;
    logic [1:0] cfg_oe_mode = 2'd0;
    logic       cfg_oe_pick = 1'b0;
    logic       cfg_pin_capture = 1'b0;

    logic fb_out, pin_out, pin_oe;
    logic fb_bur, pin_out_bur, pin_oe_bur;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    mc_cell #(.BURIED(1'b0), .N_OE(2)) u_dut (
        .clk_a(clk), .clk_b(clk_b), .sum_in(sum_in), .ar_in(ar_in), .ap_in(ap_in),
        .oe_term(oe_term), .pin_in(pin_in), .cfg_mode(cfg_mode), .cfg_tff(cfg_tff),
        .cfg_clk_sel(cfg_clk_sel), .cfg_invert(cfg_invert), .cfg_oe_mode(cfg_oe_mode),
        .cfg_oe_pick(cfg_oe_pick), .cfg_pin_capture(cfg_pin_capture),
        .fb_out(fb_out), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    mc_cell #(.BURIED(1'b1), .N_OE(2)) u_bur (
        .clk_a(clk), .clk_b(clk_b), .sum_in(sum_in), .ar_in(ar_in), .ap_in(ap_in),
        .oe_term(oe_term), .pin_in(pin_in), .cfg_mode(cfg_mode), .cfg_tff(cfg_tff),
        .cfg_clk_sel(cfg_clk_sel), .cfg_invert(cfg_invert), .cfg_oe_mode(cfg_oe_mode),
        .cfg_oe_pick(cfg_oe_pick), .cfg_pin_capture(cfg_pin_capture),
        .fb_out(fb_bur), .pin_out(pin_out_bur), .pin_oe(pin_oe_bur)
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic after_edge();
        @(posedge clk);
        #5;
    endtask

    task automatic quiet_point();  // both lines low, far from an edge
        @(negedge clk);
        #2;
    endtask

    task automatic pulse_b();
        clk_b = 1'b1; #2; clk_b = 1'b0; #1;
    endtask

    task automatic t_reset_state();
        #5;
        check("R6 clear at start fb", fb_out, 1'b0);
        check("R7 clear at start pin", pin_out, 1'b0);
        check("R8 enable off at start", pin_oe, 1'b0);
        ap_in = 1'b1; #1;
        check("R6 clear beats set", fb_out, 1'b0);
        ap_in = 1'b0; #1; ar_in = 1'b0; #1;
        check("R6 held after clear", fb_out, 1'b0);
        ap_in = 1'b1; #1;
        check("R6 set without clock", fb_out, 1'b1);
        ap_in = 1'b0; #1;
        check("R6 set holds", fb_out, 1'b1);
    endtask

    task automatic t_comb();
        quiet_point();
        cfg_mode = 2'd0; sum_in = 1'b0; #1;
        check("R1 comb low", fb_out, 1'b0);
        sum_in = 1'b1; #1;
        check("R1 comb high", fb_out, 1'b1);
        cfg_mode = 2'd3; sum_in = 1'b0; #1;
        check("R1 mode 3 comb", fb_out, 1'b0);
    endtask

    task automatic t_dff();
        quiet_point();
        cfg_mode = 2'd1; cfg_tff = 1'b0; cfg_clk_sel = 1'b0; sum_in = 1'b0;
        after_edge();
        check("R2 capture 0", fb_out, 1'b0);
        sum_in = 1'b1; #1;
        check("R2 hold between edges", fb_out, 1'b0);
        after_edge();
        check("R2 capture 1", fb_out, 1'b1);
    endtask

    task automatic t_tff();
        cfg_tff = 1'b1; sum_in = 1'b1;
        after_edge();
        check("R3 toggle to 0", fb_out, 1'b0);
        after_edge();
        check("R3 toggle to 1", fb_out, 1'b1);
        sum_in = 1'b0;
        after_edge();
        check("R3 hold on 0", fb_out, 1'b1);
        after_edge();
        check("R3 hold again", fb_out, 1'b1);
    endtask

    task automatic t_clk_select();
        quiet_point();
        cfg_tff = 1'b0; cfg_clk_sel = 1'b1; sum_in = 1'b0;
        pulse_b();
        check("R4 capture on clk_b", fb_out, 1'b0);
        sum_in = 1'b1;
        after_edge();
        check("R4 clk_a ignored", fb_out, 1'b0);
        pulse_b();
        check("R4 clk_b edge", fb_out, 1'b1);
        quiet_point();
        cfg_clk_sel = 1'b0; sum_in = 1'b0;
        pulse_b();
        check("R4 clk_b ignored", fb_out, 1'b1);
        after_edge();
        check("R4 clk_a edge", fb_out, 1'b0);
    endtask

    task automatic t_latch();
        quiet_point();
        cfg_mode = 2'd2; cfg_clk_sel = 1'b1; clk_b = 1'b0;
        sum_in = 1'b1; #1;
        check("R5 transparent 1", fb_out, 1'b1);
        sum_in = 1'b0; #1;
        check("R5 transparent 0", fb_out, 1'b0);
        clk_b = 1'b1; #1;
        sum_in = 1'b1; #1;
        check("R5 hold while high", fb_out, 1'b0);
        clk_b = 1'b0; #1;
        check("R5 reopen", fb_out, 1'b1);
    endtask

    task automatic t_polarity();
        quiet_point();
        cfg_mode = 2'd0; cfg_invert = 1'b1; sum_in = 1'b0; #1;
        check("R7 comb inverted fb", fb_out, 1'b1);
        check("R7 comb inverted pin", pin_out, 1'b1);
        cfg_mode = 2'd1; cfg_clk_sel = 1'b1;
        ar_in = 1'b1; #1; ar_in = 1'b0; #1;
        check("R7 cleared shows 1 fb", fb_out, 1'b1);
        check("R7 cleared shows 1 pin", pin_out, 1'b1);
        ap_in = 1'b1; #1; ap_in = 1'b0; #1;
        check("R7 set shows 0", pin_out, 1'b0);
        cfg_invert = 1'b0;
    endtask

    task automatic t_oe();
        oe_term = 2'b10;
        cfg_oe_mode = 2'd1; #1;
        check("R8 always on", pin_oe, 1'b1);
        cfg_oe_mode = 2'd2; cfg_oe_pick = 1'b0; #1;
        check("R8 term 0", pin_oe, 1'b0);
        cfg_oe_pick = 1'b1; #1;
        check("R8 term 1", pin_oe, 1'b1);
        oe_term = 2'b01; #1;
        check("R8 term 1 follows", pin_oe, 1'b0);
        cfg_oe_mode = 2'd3; oe_term = 2'b11; #1;
        check("R8 mode 3 off", pin_oe, 1'b0);
        cfg_oe_mode = 2'd0; #1;
        check("R8 never", pin_oe, 1'b0);
    endtask

    task automatic t_buried();
        quiet_point();
        cfg_oe_mode = 2'd1; cfg_mode = 2'd2; cfg_clk_sel = 1'b1; clk_b = 1'b0;
        sum_in = 1'b0; pin_in = 1'b1; cfg_pin_capture = 1'b1; #1;
        check("R9 buried enable low", pin_oe_bur, 1'b0);
        check("R9 buried drive low", pin_out_bur, 1'b0);
        check("R9 buried captures pin", fb_bur, 1'b1);
        check("R9 pin cell ignores capture", fb_out, 1'b0);
        cfg_pin_capture = 1'b0; #1;
        check("R9 buried back to sum", fb_bur, 1'b0);
        cfg_oe_mode = 2'd0;
    endtask

    initial begin
        t_reset_state();
        t_comb();
        t_dff();
        t_tff();
        t_clk_select();
        t_latch();
        t_polarity();
        t_oe();
        t_buried();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(20 * 200000);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule